// File: doc/BRIEF.md
# Lockable GPIO Pin Event Controller

This block manages a bank of general-purpose pins grouped into ports of equal size. Software reaches every pin through a small indexed register window: a selector register names one pin, and the other window registers then act on that pin alone. These are its 8-bit configuration, its output data bit, its interrupt enable and its event status. Each pin drives output-enable, output-type and pull-up controls to the pad logic, plus an output data value.

Every pin has a sticky lock bit. Once software sets it, the pin's drive settings and output value are frozen until the next reset. Pins in the lower, event-capable ports also watch their input. The input passes through a two-flop synchroniser and an optional debounce filter. An edge or level of a chosen polarity then sets a status bit. Enabled status bits are ORed into one interrupt request.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, the selector reads 0. Event-capable pins hold configuration 44h, the other pins 04h, and the designated pin `ZERO_PIN` holds 00h. Output data, interrupt enables and status are all 0.
- R2: Writing index F0h stores the pin number in the selector, and reading F0h returns it. Index F1h reads and writes the configuration of the selected pin. Its bit 0 is output enable, bit 1 is output type (1 = push-pull), bit 2 is pull-up, bit 3 is lock, bit 4 is event type, bit 5 is polarity, and bit 6 is debounce enable.
- R3: Bit 7 of every configuration reads 0. On pins outside the event-capable ports, bits 4 to 6 read 0 and writes to them are ignored.
- R4: A write with bit 3 set sets the lock. No write can clear it. Only reset clears it.
- R5: The outputs `pinOe`, `pinPushPull`, `pinPullUp` and `pinOut` follow configuration bits 0, 1, 2 and the output data bit. While a pin is locked, writes change none of these four for that pin. The write that sets the lock still updates bits 0 to 2.
- R6: With event type 0 (edge), polarity 0 detects a falling edge and polarity 1 a rising edge. A detected edge sets the pin's status bit (index F4h, bit 0). The bit stays set until a write of 1 to F4h bit 0.
- R7: With event type 1 (level), the status bit is 1 exactly while the filtered input equals the polarity bit. A clear write does not lower it while that level is present.
- R8: With debounce enabled, an input change reaches the detector only after it has been stable for `DEB_CYCLES` cycles, so shorter pulses are dropped. With debounce disabled, a two-cycle pulse is detected.
- R9: `irq` is 1 when any pin has both its status bit and its enable bit (index F3h, bit 0) set. Pins outside the event-capable ports never have a set status bit or a set enable bit.
- R10: Index F2h bit 0 holds the selected pin's output data. Writes to it are ignored while the pin is locked. Bit 1 reads the pin's synchronised (and filtered) input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| pinIn | input | NUM_PORTS*PINS_PER_PORT | Pin input levels (asynchronous) |
| pinOut | output | NUM_PORTS*PINS_PER_PORT | Output data per pin |
| pinOe | output | NUM_PORTS*PINS_PER_PORT | Output enable per pin |
| pinPushPull | output | NUM_PORTS*PINS_PER_PORT | 1 = push-pull, 0 = open-drain |
| pinPullUp | output | NUM_PORTS*PINS_PER_PORT | Pull-up enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with two ports of four pins each and one event-capable port. This gives four event pins and four plain pins, with `ZERO_PIN` set to 6. With this shape, every reset flavour, the reserved-bit masking and the plain-pin rules can be seen within one small select range. The debounce period is shortened to 6 cycles. A 3-cycle glitch then falls clearly below the threshold, while a held level passes in a few tens of cycles. Lock, edge polarity, level clearing and interrupt masking are all exercised through the register window and the pin outputs.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam logic [7:0] IDX_SEL  = 8'hF0;
  localparam logic [7:0] IDX_CFG  = 8'hF1;
  localparam logic [7:0] IDX_DATA = 8'hF2;
  localparam logic [7:0] IDX_IEN  = 8'hF3;
  localparam logic [7:0] IDX_STAT = 8'hF4;

  localparam int CFG_OE   = 0;
  localparam int CFG_PP   = 1;
  localparam int CFG_PU   = 2;
  localparam int CFG_LOCK = 3;
  localparam int CFG_LVL  = 4;
  localparam int CFG_POL  = 5;
  localparam int CFG_DEB  = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_SEL, RD_CFG, RD_DATA, RD_IEN, RD_STAT
  } rdSrc_e;

  typedef struct packed {
    logic   cfgWr;
    logic   dataWr;
    logic   ienWr;
    logic   statClr;
    rdSrc_e rdSrc;
  } strobes_t;
endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int SELW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWr,
  input  logic [7:0]      regAddr,
  input  logic [SELW-1:0] selData,
  output strobes_t        strobes,
  output logic [SELW-1:0] pinSel
);
  logic selValid;

  always_ff @(posedge clk) begin
    if (!rstN) pinSel <= '0;
    else if (regWr && regAddr == IDX_SEL) pinSel <= selData;
  end

  assign selValid = (32'(pinSel) < NUM_PINS);

  always_comb begin
    strobes = '0;
    strobes.rdSrc = RD_NONE;
    if (regAddr == IDX_SEL) begin
      strobes.rdSrc = RD_SEL;
    end else if (selValid) begin
      case (regAddr)
        IDX_CFG:  begin strobes.cfgWr   = regWr; strobes.rdSrc = RD_CFG;  end
        IDX_DATA: begin strobes.dataWr  = regWr; strobes.rdSrc = RD_DATA; end
        IDX_IEN:  begin strobes.ienWr   = regWr; strobes.rdSrc = RD_IEN;  end
        IDX_STAT: begin strobes.statClr = regWr; strobes.rdSrc = RD_STAT; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int EVT_PINS   = 16,
  parameter int ZERO_PIN   = 30,
  parameter int DEB_CYCLES = 16,
  localparam int SELW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int CNTW = $clog2(DEB_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [SELW-1:0]     pinSel,
  input  logic [6:0]          wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [7:0]          rdData,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinPushPull,
  output logic [NUM_PINS-1:0] pinPullUp,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] lockVec,
  output logic [NUM_PINS-1:0] statVec,
  output logic [NUM_PINS-1:0] ienVec,
  output logic                irq
);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(DEB_CYCLES - 1);

  logic [7:0]          cfgAll [NUM_PINS];
  logic [NUM_PINS-1:0] filtVec;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam bit IS_EVT = (g < EVT_PINS);
    localparam logic [7:0] RST_CFG = (g == ZERO_PIN) ? 8'h00 : (IS_EVT ? 8'h44 : 8'h04);

    logic       hit;
    logic [7:0] cfgQ, cfgNext;
    logic       doutQ;
    logic [1:0] syncQ;

    assign hit = (pinSel == SELW'(g));

    always_comb begin
      cfgNext = 8'h00;
      cfgNext[CFG_PU:CFG_OE] = cfgQ[CFG_LOCK] ? cfgQ[CFG_PU:CFG_OE] : wrData[CFG_PU:CFG_OE];
      cfgNext[CFG_LOCK] = cfgQ[CFG_LOCK] | wrData[CFG_LOCK];
      if (IS_EVT) cfgNext[CFG_DEB:CFG_LVL] = wrData[CFG_DEB:CFG_LVL];
    end

    always_ff @(posedge clk) begin
      if (!rstN) cfgQ <= RST_CFG;
      else if (strobes.cfgWr && hit) cfgQ <= cfgNext;
    end

    always_ff @(posedge clk) begin
      if (!rstN) doutQ <= 1'b0;
      else if (strobes.dataWr && hit && !cfgQ[CFG_LOCK]) doutQ <= wrData[0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= 2'b11;
      else syncQ <= {syncQ[0], pinIn[g]};
    end

    assign cfgAll[g]      = cfgQ;
    assign pinOe[g]       = cfgQ[CFG_OE];
    assign pinPushPull[g] = cfgQ[CFG_PP];
    assign pinPullUp[g]   = cfgQ[CFG_PU];
    assign lockVec[g]     = cfgQ[CFG_LOCK];
    assign pinOut[g]      = doutQ;

    if (IS_EVT) begin : g_evt
      logic [CNTW-1:0] cntQ;
      logic filtQ, prevQ, statQ, ienQ, edgeHit, lvlActive;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cntQ  <= '0;
          filtQ <= 1'b1;
        end else if (!cfgQ[CFG_DEB]) begin
          cntQ  <= '0;
          filtQ <= syncQ[1];
        end else if (syncQ[1] == filtQ) begin
          cntQ  <= '0;
        end else if (cntQ == CNT_LAST) begin
          cntQ  <= '0;
          filtQ <= syncQ[1];
        end else begin
          cntQ  <= cntQ + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) prevQ <= 1'b1;
        else prevQ <= filtQ;
      end

      assign edgeHit   = cfgQ[CFG_POL] ? (filtQ & ~prevQ) : (~filtQ & prevQ);
      assign lvlActive = (filtQ == cfgQ[CFG_POL]);

      always_ff @(posedge clk) begin
        if (!rstN) statQ <= 1'b0;
        else if (cfgQ[CFG_LVL]) statQ <= lvlActive;
        else if (edgeHit) statQ <= 1'b1;
        else if (strobes.statClr && hit && wrData[0]) statQ <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rstN) ienQ <= 1'b0;
        else if (strobes.ienWr && hit) ienQ <= wrData[0];
      end

      assign filtVec[g] = filtQ;
      assign statVec[g] = statQ;
      assign ienVec[g]  = ienQ;
    end else begin : g_plain
      assign filtVec[g] = syncQ[1];
      assign statVec[g] = 1'b0;
      assign ienVec[g]  = 1'b0;
    end
  end

  assign irq = |(statVec & ienVec);

  always_comb begin
    rdData = 8'h00;
    case (strobes.rdSrc)
      RD_SEL:  rdData = 8'(pinSel);
      RD_CFG:  rdData = cfgAll[pinSel];
      RD_DATA: rdData = {6'b0, filtVec[pinSel], pinOut[pinSel]};
      RD_IEN:  rdData = {7'b0, ienVec[pinSel]};
      RD_STAT: rdData = {7'b0, statVec[pinSel]};
      default: rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int EVT_PORTS     = 2,
  parameter int ZERO_PIN      = 30,
  parameter int DEB_CYCLES    = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 regWr,
  input  logic [7:0]                           regAddr,
  input  logic [7:0]                           regWrData,
  output logic [7:0]                           regRdData,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pinIn,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pinOut,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pinOe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pinPushPull,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pinPullUp,
  output logic                                 irq
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int EVT_PINS = EVT_PORTS * PINS_PER_PORT;
  localparam int SELW     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  strobes_t            strobes;
  logic [SELW-1:0]     pinSel;
  logic [NUM_PINS-1:0] lockVec, statVec, ienVec;

  gpio_evt_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .selData(regWrData[SELW-1:0]), .strobes(strobes), .pinSel(pinSel)
  );

  gpio_evt_datapath #(
    .NUM_PINS(NUM_PINS), .EVT_PINS(EVT_PINS),
    .ZERO_PIN(ZERO_PIN), .DEB_CYCLES(DEB_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pinSel(pinSel),
    .wrData(regWrData[6:0]), .pinIn(pinIn), .rdData(regRdData),
    .pinOe(pinOe), .pinPushPull(pinPushPull), .pinPullUp(pinPullUp),
    .pinOut(pinOut), .lockVec(lockVec), .statVec(statVec),
    .ienVec(ienVec), .irq(irq)
  );
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int EVT_PINS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] pinPushPull,
  input logic [NUM_PINS-1:0] pinPullUp,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] lockVec,
  input logic [NUM_PINS-1:0] statVec,
  input logic [NUM_PINS-1:0] ienVec,
  input logic                irq
);
  function automatic logic [NUM_PINS-1:0] evtMaskCalc();
    logic [NUM_PINS-1:0] m = '0;
    for (int i = 0; i < NUM_PINS; i++) m[i] = (i < EVT_PINS);
    return m;
  endfunction
  localparam logic [NUM_PINS-1:0] EVT_MASK = evtMaskCalc();

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockVec) & ~lockVec) == '0); // R4

  AST_LOCKED_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOe ^ $past(pinOe)) | (pinPushPull ^ $past(pinPushPull)) |
      (pinPullUp ^ $past(pinPullUp)) | (pinOut ^ $past(pinOut))) & $past(lockVec)) == '0); // R5

  AST_PLAIN_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((statVec | ienVec) & ~EVT_MASK) == '0); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statVec != '0)); // R9
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.NUM_PINS(NUM_PINS), .EVT_PINS(EVT_PINS)) u_chk (.*);

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;
  localparam int NP = 8;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00, regRdData;
  logic [NP-1:0] pinIn = '1, pinOut, pinOe, pinPushPull, pinPullUp;
  logic irq;

  always #2.5 clk = ~clk;

  gpio_evt_bank #(
    .NUM_PORTS(2), .PINS_PER_PORT(4), .EVT_PORTS(1),
    .ZERO_PIN(6), .DEB_CYCLES(6)
  ) u_gpio_evt_bank (.*);

  typedef struct {
    int         src;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // monitor: pop expected items and compare away from the active edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = regRdData;
        1: act = {7'b0, irq};
        2: act = pinOe;
        3: act = pinOut;
        4: act = pinPullUp;
        default: act = pinPushPull;
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic expect_item(int src, logic [7:0] a, logic [7:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.src = src; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic setPin(int p, logic v);
    @(posedge clk); #1;
    pinIn[p] = v;
  endtask

  initial begin
    idle(4); #1 rstN = 1'b1;
    // R1 reset state
    expect_item(0, 8'hF0, 8'h00, "R1 selector");
    expect_item(0, 8'hF1, 8'h44, "R1 event pin cfg");
    expect_item(4, 8'h00, 8'hBF, "R1 pull-up vector");
    expect_item(1, 8'h00, 8'h00, "R1 irq idle");
    wr(8'hF0, 8'h05);
    expect_item(0, 8'hF0, 8'h05, "R2 selector readback");
    expect_item(0, 8'hF1, 8'h04, "R1 plain pin cfg");
    wr(8'hF0, 8'h06);
    expect_item(0, 8'hF1, 8'h00, "R1 zero pin cfg");
    // R2 / R3 window and reserved bits
    wr(8'hF0, 8'h05); wr(8'hF1, 8'h77);
    expect_item(0, 8'hF1, 8'h07, "R3 plain pin event bits");
    wr(8'hF0, 8'h01); wr(8'hF1, 8'hF7);
    expect_item(0, 8'hF1, 8'h77, "R3 bit7 reads 0 / R2 layout");
    expect_item(2, 8'h00, 8'h22, "R5 pinOe follows bit0");
    expect_item(5, 8'h00, 8'h22, "R5 pinPushPull follows bit1");
    // R4 / R5 lock on pin 5
    wr(8'hF0, 8'h05); wr(8'hF2, 8'h01);
    expect_item(3, 8'h00, 8'h20, "R5 pinOut follows data");
    wr(8'hF1, 8'h0D);
    expect_item(0, 8'hF1, 8'h0D, "R4 lock set with drive bits");
    wr(8'hF1, 8'h00);
    expect_item(0, 8'hF1, 8'h0D, "R4 lock not cleared");
    wr(8'hF2, 8'h00);
    expect_item(3, 8'h00, 8'h20, "R5 locked data unchanged");
    expect_item(5, 8'h00, 8'h02, "R5 locked push-pull");
    expect_item(0, 8'hF2, 8'h03, "R10 locked data readback");
    // R10 data register and input level, pin 4
    wr(8'hF0, 8'h04); wr(8'hF2, 8'h01);
    expect_item(0, 8'hF2, 8'h03, "R10 data and input high");
    setPin(4, 1'b0); idle(5);
    expect_item(0, 8'hF2, 8'h01, "R10 input low");
    // R6 edge events on pin 0
    wr(8'hF0, 8'h00); wr(8'hF1, 8'h00); wr(8'hF3, 8'h01);
    expect_item(0, 8'hF3, 8'h01, "R9 enable readback");
    setPin(0, 1'b0); idle(6);
    expect_item(0, 8'hF4, 8'h01, "R6 falling edge sets status");
    expect_item(1, 8'h00, 8'h01, "R9 irq on enabled status");
    setPin(0, 1'b1); idle(6);
    expect_item(0, 8'hF4, 8'h01, "R6 status sticky");
    wr(8'hF4, 8'h01);
    expect_item(0, 8'hF4, 8'h00, "R6 write-one clears");
    expect_item(1, 8'h00, 8'h00, "R9 irq drops");
    wr(8'hF1, 8'h20);
    setPin(0, 1'b0); idle(6);
    expect_item(0, 8'hF4, 8'h00, "R6 rising polarity ignores fall");
    setPin(0, 1'b1); idle(6);
    expect_item(0, 8'hF4, 8'h01, "R6 rising edge sets status");
    wr(8'hF4, 8'h01);
    // R7 level events on pin 2 (enable off)
    wr(8'hF0, 8'h02); wr(8'hF1, 8'h10);
    expect_item(0, 8'hF4, 8'h00, "R7 inactive level");
    setPin(2, 1'b0); idle(6);
    expect_item(0, 8'hF4, 8'h01, "R7 low level active");
    expect_item(1, 8'h00, 8'h00, "R9 masked status no irq");
    wr(8'hF4, 8'h01);
    expect_item(0, 8'hF4, 8'h01, "R7 clear ignored while active");
    setPin(2, 1'b1); idle(6);
    expect_item(0, 8'hF4, 8'h00, "R7 level gone");
    // R8 debounce on pin 3
    wr(8'hF0, 8'h03); wr(8'hF1, 8'h40); wr(8'hF3, 8'h01);
    setPin(3, 1'b0); idle(2); setPin(3, 1'b1); idle(20);
    expect_item(0, 8'hF4, 8'h00, "R8 glitch filtered");
    setPin(3, 1'b0); idle(4);
    expect_item(0, 8'hF4, 8'h00, "R8 not yet stable");
    idle(12);
    expect_item(0, 8'hF4, 8'h01, "R8 stable level passed");
    expect_item(1, 8'h00, 8'h01, "R8 irq after debounce");
    expect_item(0, 8'hF2, 8'h00, "R10 filtered input low");
    setPin(3, 1'b1); idle(20); wr(8'hF4, 8'h01);
    wr(8'hF0, 8'h00); wr(8'hF1, 8'h00); wr(8'hF4, 8'h01);
    setPin(0, 1'b0); idle(1); setPin(0, 1'b1); idle(6);
    expect_item(0, 8'hF4, 8'h01, "R8 short pulse without debounce");
    wr(8'hF4, 8'h01);
    // R9 plain pin 4
    wr(8'hF0, 8'h04); wr(8'hF3, 8'h01);
    expect_item(0, 8'hF3, 8'h00, "R9 plain pin enable stays 0");
    wr(8'hF1, 8'h17);
    expect_item(0, 8'hF1, 8'h07, "R3 plain pin type ignored");
    setPin(4, 1'b1); idle(4); setPin(4, 1'b0); idle(6);
    expect_item(0, 8'hF4, 8'h00, "R9 plain pin no status");
    expect_item(1, 8'h00, 8'h00, "R9 plain pin no irq");
    // R4 reset clears lock
    @(posedge clk); #1 rstN = 1'b0; idle(3); #1 rstN = 1'b1;
    wr(8'hF0, 8'h05);
    expect_item(0, 8'hF1, 8'h04, "R4 reset clears lock");
    expect_item(3, 8'h00, 8'h00, "R1 data cleared by reset");
    idle(2);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule